// File: doc/BRIEF.md
# PLL Relock Ready Timer

This block decides when the output of a phase-locked loop may serve as the system clock after its configuration has been changed. It keeps the crystal-select field that software writes, tracks the PLL power-down control, and, on a qualifying change, reloads a down counter clocked by the reference oscillator. While that counter runs, a ready flag is held low and any software request to run the system from the PLL is held off. The clock stays on its previous source until the count ends, and then the PLL is taken automatically.

Only two events count as qualifying changes. The first is a write that gives the crystal-select field a value different from the one it holds. The second is the PLL leaving power-down. A write of the value already held is absorbed without effect. Entering power-down drops the ready flag in the same cycle and parks the counter at zero. The reload value is a parameter that defaults to 0x1200 oscillator cycles.

Top module: `pll_relock_guard`

## Requirements
- R1: After reset the ready flag and the PLL-select output are both 0. The stored crystal field equals parameter XTAL_RST. The power-down state is taken as set, so ready stays 0 for as long as `pll_pd` is held at 1.
- R2: When `pll_pd` is sampled 0 on a clock edge after having been 1 (or after reset), `pll_ready` is 0 for exactly RELOCK_LOAD cycles after that edge. It reads 1 after edge RELOCK_LOAD following it.
- R3: A write (`cfg_wr`=1) whose `cfg_xtal` differs from the stored crystal field, sampled with `pll_pd`=0, clears `pll_ready` after that edge and restarts the full RELOCK_LOAD-cycle count.
- R4: A write whose `cfg_xtal` equals the stored crystal field has no effect: a ready flag that is 1 stays 1, and a running count is not restarted.
- R5: Once `pll_ready` is 1 it stays 1 until the next qualifying change (R2, R3) or until power-down.
- R6: While `pll_pd` is 1, `pll_ready` is 0 in the same cycle, combinationally, and the counter stays at zero.
- R7: `sysclk_sel_pll` is 1 only when `use_pll_req` is 1 and `pll_ready` is 1. A request made while not ready keeps the clock on its previous source (output 0), and the PLL is selected without a new request as soon as ready rises.
- R8: A qualifying change made while a count is running reloads the full RELOCK_LOAD value. Ready then rises RELOCK_LOAD cycles after the later change.
- R9: Crystal-field writes are stored while in power-down. After power-up, a write of that stored value counts as a same-value write (R4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Reference oscillator clock |
| rst_osc_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the crystal-select field |
| cfg_xtal | input | XTAL_W | Crystal-select write data |
| pll_pd | input | 1 | PLL power-down control, 1 = powered down |
| use_pll_req | input | 1 | Software request to run the system clock from the PLL |
| pll_ready | output | 1 | PLL locked and usable |
| sysclk_sel_pll | output | 1 | Gated select of the PLL as system clock source |

## Verification
The bench builds the block with RELOCK_LOAD = 6, XTAL_W = 4 and XTAL_RST = 3. This makes every relock window a handful of cycles, so the exact length of each window can be counted step by step. The short windows also put restarts in the middle of a count, power-down in the middle of a count, and same-value writes during both counting and ready within a short run. A behavioural model is compared with both outputs on every cycle. Directed checks on window length sit beside those comparisons.

// File: rtl/prt_pkg.sv
// Package: shared types and helpers for the PLL relock ready timer.
// Assumes: nothing beyond IEEE 1800-2017.
package prt_pkg;

    // Phase of the relock timer.
    typedef enum logic [1:0] {
        RL_IDLE  = 2'd0,   // powered down or out of reset, not usable
        RL_COUNT = 2'd1,   // relock window running
        RL_READY = 2'd2    // count completed, PLL usable
    } relock_phase_e;

    // Width needed to hold a load value of 'load'.
    function automatic int relock_cnt_w(input int load);
        return (load < 2) ? 1 : $clog2(load + 1);
    endfunction

endpackage

// File: rtl/prt_xtal_reg.sv
// Module: crystal-select field holder with change detection.
// Holds the software-written crystal field and flags a write whose data
// differs from the held value. Assumes cfg_wr is a one-cycle strobe.
module prt_xtal_reg #(
    parameter int           XTAL_W   = 5,
    parameter logic [XTAL_W-1:0] XTAL_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [XTAL_W-1:0] wdata,
    output logic [XTAL_W-1:0] xtal_q,
    output logic              changed
);

    // Detect a write that alters the stored field.
    always_comb begin
        changed = wr && (wdata != xtal_q);
    end

    // Store every write, also in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xtal_q <= XTAL_RST;
        end else if (wr) begin
            xtal_q <= wdata;
        end
    end

endmodule

// File: rtl/prt_pd_track.sv
// Module: power-down tracker.
// Registers the power-down control and reports the power-down to normal
// transition. Reset takes the PLL as powered down, so a low control right
// after reset counts as a wake-up.
module prt_pd_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    output logic pd_q,
    output logic wake
);

    // Wake-up when previously down and now up.
    always_comb begin
        wake = pd_q && !pd;
    end

    // Remember last sampled power-down level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q <= 1'b1;
        end else begin
            pd_q <= pd;
        end
    end

endmodule

// File: rtl/prt_relock_cnt.sv
// Module: relock down counter with ready phase.
// Loads LOAD on restart, counts down once per clock and enters the ready
// phase on the edge the count reaches zero. Hold (power-down) forces the
// idle phase with the counter at zero and wins over restart.
module prt_relock_cnt
    import prt_pkg::*;
#(
    parameter int LOAD  = 32'h1200,
    localparam int CNT_W = relock_cnt_w(LOAD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ready
);

    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    relock_phase_e phase_q;

    // Ready only in the ready phase.
    always_comb begin
        ready = (phase_q == RL_READY);
    end

    // Counter and phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= RL_IDLE;
        end else if (hold) begin
            cnt_q   <= '0;
            phase_q <= RL_IDLE;
        end else if (restart) begin
            cnt_q   <= LOAD_V;
            phase_q <= RL_COUNT;
        end else if (cnt_q != '0) begin
            cnt_q   <= cnt_q - ONE_V;
            phase_q <= (cnt_q == ONE_V) ? RL_READY : RL_COUNT;
        end
    end

endmodule

// File: rtl/pll_relock_guard.sv
// Module: top of the PLL relock ready timer.
// Combines the crystal field holder, power-down tracker and relock counter.
// The ready output is masked by the live power-down input so power-down
// removes it in the same cycle. The PLL select is the software request
// gated by ready. Assumes all inputs are synchronous to clk_osc.
module pll_relock_guard #(
    parameter int                XTAL_W      = 5,
    parameter logic [XTAL_W-1:0] XTAL_RST    = '0,
    parameter int                RELOCK_LOAD = 32'h1200,
    localparam int               CNT_W       = prt_pkg::relock_cnt_w(RELOCK_LOAD)
) (
    input  logic              clk_osc,
    input  logic              rst_osc_n,
    input  logic              cfg_wr,
    input  logic [XTAL_W-1:0] cfg_xtal,
    input  logic              pll_pd,
    input  logic              use_pll_req,
    output logic              pll_ready,
    output logic              sysclk_sel_pll
);

    logic [XTAL_W-1:0] xtal_q;
    logic              xtal_chg;
    logic              pd_q;
    logic              wake;
    logic              restart;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_ready;

    prt_xtal_reg #(
        .XTAL_W   (XTAL_W),
        .XTAL_RST (XTAL_RST)
    ) u_xtal (
        .clk     (clk_osc),
        .rst_n   (rst_osc_n),
        .wr      (cfg_wr),
        .wdata   (cfg_xtal),
        .xtal_q  (xtal_q),
        .changed (xtal_chg)
    );

    prt_pd_track u_pd (
        .clk   (clk_osc),
        .rst_n (rst_osc_n),
        .pd    (pll_pd),
        .pd_q  (pd_q),
        .wake  (wake)
    );

    // Either qualifying change restarts the window.
    always_comb begin
        restart = xtal_chg || wake;
    end

    prt_relock_cnt #(
        .LOAD (RELOCK_LOAD)
    ) u_cnt (
        .clk     (clk_osc),
        .rst_n   (rst_osc_n),
        .hold    (pll_pd),
        .restart (restart),
        .cnt_q   (cnt_q),
        .ready   (cnt_ready)
    );

    // Outputs: ready masked by live power-down, select gated by ready.
    always_comb begin
        pll_ready      = cnt_ready && !pll_pd;
        sysclk_sel_pll = use_pll_req && pll_ready;
    end

endmodule

// File: rtl/pll_relock_guard_chk.sv
// Module: assertion checker for pll_relock_guard, attached by bind.
// Assumes it observes the top's ports plus the stored crystal field and count.
module pll_relock_guard_chk #(
    parameter int XTAL_W      = 5,
    parameter int RELOCK_LOAD = 32'h1200,
    parameter int CNT_W       = 14
) (
    input logic              clk_osc,
    input logic              rst_osc_n,
    input logic              cfg_wr,
    input logic [XTAL_W-1:0] cfg_xtal,
    input logic              pll_pd,
    input logic              use_pll_req,
    input logic              pll_ready,
    input logic              sysclk_sel_pll,
    input logic [XTAL_W-1:0] xtal_q,
    input logic [CNT_W-1:0]  cnt_q
);

    // R2: leaving power-down opens a not-ready window.
    p_wake_not_ready_r2: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
        $fell(pll_pd) |=> !pll_ready);

    // R2: count never exceeds the load value.
    p_cnt_bound_r2: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
        cnt_q <= CNT_W'(RELOCK_LOAD));

    // R3: a differing write clears ready.
    p_diff_write_r3: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
        (cfg_wr && (cfg_xtal != xtal_q) && !pll_pd) |=> !pll_ready);

    // R4: a same-value write while ready keeps ready unless power-down follows.
    p_same_write_r4: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
        (pll_ready && cfg_wr && (cfg_xtal == xtal_q)) |=> (pll_ready || pll_pd));

    // R5: ready only with an expired count.
    p_ready_zero_r5: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
        pll_ready |-> (cnt_q == '0));

    // R6: power-down removes ready at once.
    p_pd_no_ready_r6: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
        pll_pd |-> !pll_ready);

    // R6: counter idles during power-down.
    p_pd_idle_r6: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
        pll_pd |=> (cnt_q == '0));

    // R7: a pending request is honoured as soon as ready rises.
    p_auto_select_r7: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
        ($rose(pll_ready) && use_pll_req) |-> sysclk_sel_pll);

    // R7: no PLL select without ready.
    p_no_sel_unready_r7: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
        !pll_ready |-> !sysclk_sel_pll);

endmodule

bind pll_relock_guard pll_relock_guard_chk #(
    .XTAL_W      (XTAL_W),
    .RELOCK_LOAD (RELOCK_LOAD),
    .CNT_W       (CNT_W)
) u_chk (
    .clk_osc        (clk_osc),
    .rst_osc_n      (rst_osc_n),
    .cfg_wr         (cfg_wr),
    .cfg_xtal       (cfg_xtal),
    .pll_pd         (pll_pd),
    .use_pll_req    (use_pll_req),
    .pll_ready      (pll_ready),
    .sysclk_sel_pll (sysclk_sel_pll),
    .xtal_q         (xtal_q),
    .cnt_q          (cnt_q)
);

// File: tb/pll_relock_guard_test.sv
module pll_relock_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam int XW         = 4;
    localparam int LOAD       = 6;
    localparam logic [XW-1:0] XRST = 4'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [XW-1:0] wdata = '0;
    logic          pd = 1'b1;
    logic          req = 1'b0;
    logic          ready;
    logic          sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int ref_cnt = 0;
    bit ref_rdy = 0;
    int ref_xtal = 0;
    bit ref_pd_prev = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_relock_guard #(
        .XTAL_W      (XW),
        .XTAL_RST    (XRST),
        .RELOCK_LOAD (LOAD)
    ) uut (
        .clk_osc        (clk),
        .rst_osc_n      (rst_n),
        .cfg_wr         (wr),
        .cfg_xtal       (wdata),
        .pll_pd         (pd),
        .use_pll_req    (req),
        .pll_ready      (ready),
        .sysclk_sel_pll (sel)
    );

    // Reference model: advances once per rising edge from sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt = 0; ref_rdy = 0; ref_xtal = int'(XRST); ref_pd_prev = 1;
        end else begin
            bit trig;
            trig = (wr && int'(wdata) != ref_xtal) || (ref_pd_prev && !pd);
            if (wr) ref_xtal = int'(wdata);
            if (pd) begin
                ref_cnt = 0; ref_rdy = 0;
            end else if (trig) begin
                ref_cnt = LOAD; ref_rdy = 0;
            end else if (ref_cnt > 0) begin
                ref_cnt = ref_cnt - 1;
                if (ref_cnt == 0) ref_rdy = 1;
            end
            ref_pd_prev = pd;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, then compare both outputs with the model.
    task automatic step(input logic w, input logic [XW-1:0] d, input logic p, input logic r);
        @(negedge clk);
        wr = w; wdata = d; pd = p; req = r;
        #1;
        check({cur_req, " ready"}, ready, ref_rdy && !pd);
        check({cur_req, " sel"},   sel,   ref_rdy && !pd && req);
    endtask

    // Count steps with ready low after a qualifying step; expect LOAD.
    task automatic count_window(input string tag, input logic r, output int lows);
        lows = 0;
        for (int i = 0; i < LOAD + 4; i++) begin
            step(1'b0, '0, 1'b0, r);
            if (!ready) lows++;
            else break;
        end
        check({tag, " window"}, 1'(lows == LOAD), 1'b1);
        if (lows != LOAD)
            $display("FAIL %s: window actual=%0d expected=%0d", tag, lows, LOAD);
    endtask

    initial begin
        int lows;
        // R1: reset with PLL powered down
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset ready", ready, 1'b0);
        check("R1 reset sel", sel, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R1";
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, 1'b1);
        check("R1 held pd ready", ready, 1'b0);

        // R2 and R7: power up with a pending request
        cur_req = "R2";
        step(1'b0, '0, 1'b0, 1'b1);
        check("R7 req while unready sel", sel, 1'b0);
        count_window("R2", 1'b1, lows);
        check("R7 auto select", sel, 1'b1);

        // R4: same value write while ready
        cur_req = "R4";
        step(1'b1, XRST, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, 1'b1);
        check("R4 same write keeps ready", ready, 1'b1);

        // R5: ready holds with no change
        cur_req = "R5";
        for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b0, 1'b1);
        check("R5 ready held", ready, 1'b1);

        // R3: differing write
        cur_req = "R3";
        step(1'b1, 4'd9, 1'b0, 1'b1);
        count_window("R3", 1'b1, lows);

        // R8: restart mid-count; R4 same write mid-count
        cur_req = "R8";
        step(1'b1, 4'd12, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        step(1'b1, 4'd12, 1'b0, 1'b0);
        step(1'b1, 4'd5, 1'b0, 1'b0);
        count_window("R8", 1'b0, lows);
        check("R7 no request no sel", sel, 1'b0);

        // R6: power-down drops ready in the same cycle
        cur_req = "R6";
        step(1'b0, '0, 1'b1, 1'b1);
        check("R6 pd immediate", ready, 1'b0);
        // R9: write while down is stored
        cur_req = "R9";
        step(1'b1, 4'd7, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b1);
        check("R6 stays down", ready, 1'b0);
        cur_req = "R2";
        step(1'b0, '0, 1'b0, 1'b1);
        count_window("R2 repower", 1'b1, lows);
        cur_req = "R9";
        step(1'b1, 4'd7, 1'b0, 1'b1);
        step(1'b0, '0, 1'b0, 1'b1);
        check("R9 stored value no restart", ready, 1'b1);

        // R6: power-down mid-count, then up again
        cur_req = "R6";
        step(1'b1, 4'd1, 1'b0, 1'b1);
        step(1'b0, '0, 1'b0, 1'b1);
        step(1'b0, '0, 1'b1, 1'b1);
        step(1'b0, '0, 1'b1, 1'b1);
        cur_req = "R2";
        step(1'b0, '0, 1'b0, 1'b1);
        count_window("R2 after abort", 1'b1, lows);

        // R7: request toggling while ready
        cur_req = "R7";
        step(1'b0, '0, 1'b0, 1'b0);
        check("R7 drop req", sel, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        check("R7 raise req", sel, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule